// File: doc/BRIEF.md
# Segmented-Address Multiplexed Bus Cycle Sequencer

This block carries out single memory or port transfers for a 16-bit processor core over a bus in which the low address bits and the data bits share one set of lines. The core hands over a request holding a segment value, an offset, a direction flag, a space select (memory or port) and write data. The block turns the segment and offset into a 20-bit physical address. It places that address on the shared lines with a one-cycle address strobe, so that external latches can hold it. It then sets the transceiver direction, asserts the active-low read or write strobe and waits for the slave's ready line before it closes the transfer.

Each transfer runs through fixed states: T1 puts the address out and strobes it. T2 turns the shared lines around and asserts the strobe. T3 samples ready. Zero or more wait states TW follow while ready stays low. T4 releases the strobe and reports completion. The request side is a valid/ready stream. A transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. While `req_ready` is low the core must keep its request fields stable; a request offered then is not taken and changes nothing on the bus. Completion is a plain one-cycle `done` pulse, and the read data sits on `rsp_rdata` from that pulse until the next read ends.

Top module: `bus_cycle_seq`

## Requirements
- R1: For a memory transfer, the physical address is (segment × 16 + offset) modulo 2^20. During T1, bits 15:0 appear on `bus_ad_out` with `bus_ad_oe` high and bits 19:16 appear on `bus_a_hi`. `bus_a_hi` holds these bits from T1 through T4.
- R2: For a port transfer (`req_mem` = 0), the offset alone is the 16-bit port number and the segment has no effect. `bus_a_hi` is zero and `bus_mem_sel` is low from T1 through T4. For a memory transfer `bus_mem_sel` is high over the same span.
- R3: `bus_addr_stb` is high for exactly one cycle, in T1, and low in every other state.
- R4: `bus_dir_tx` is high from T1 through T4 for a write and low for a read. It is low while idle.
- R5: `bus_rd_n` is low in T2, T3 and every TW of a read. `bus_wr_n` is low over the same states of a write. The strobe not in use stays high. Both strobes are high in T1, T4 and idle, and they are never low together.
- R6: For a write, `bus_ad_out` carries the write data with `bus_ad_oe` high from T2 through T4. For a read, `bus_ad_oe` is low from T2 through T4 and while idle.
- R7: `bus_rdy` is sampled only at the clock edge that ends T3 or a TW. When it is low there, one more TW follows. When it is high there, T4 follows. Its value in any other state has no effect.
- R8: On a read, `bus_ad_in` is captured at the edge where the sequencer leaves T3 or TW for T4. That value appears on `rsp_rdata` in T4, when `done` is high for exactly one cycle.
- R9: `req_ready` is high only while idle, and `busy` is high from T1 through T4. A transfer on an edge where `req_valid` and `req_ready` are both high makes the next cycle T1. A request offered while busy is not taken and does not change the address, data or strobes of the transfer in progress.
- R10: A transfer lasts 4 + N cycles from T1 to T4 inclusive, where N is the number of wait states. After T4 one idle cycle follows before a new request can be taken, so back-to-back transfers start every 5 + N cycles.
- R11: During and right after reset, the sequencer is idle. `req_ready` is high and `busy` and `done` are low. Both strobes are high, and `bus_addr_stb`, `bus_ad_oe`, `bus_dir_tx` and `bus_mem_sel` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Sequencer can take a request (idle) |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset, or port number for port transfers |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = port space |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A transfer is in progress (T1..T4) |
| done | output | 1 | One-cycle completion pulse (T4) |
| rsp_rdata | output | 16 | Data captured by the last read |
| bus_ad_out | output | 16 | Value driven onto the shared address/data lines |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 16 | Value read from the shared lines |
| bus_a_hi | output | 4 | Physical address bits 19:16 |
| bus_addr_stb | output | 1 | Address latch strobe, high in T1 |
| bus_dir_tx | output | 1 | Transceiver direction, 1 = core sends |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_mem_sel | output | 1 | 1 = memory transfer, 0 = port transfer |
| bus_rdy | input | 1 | Slave ready; low inserts wait states |

## Verification
T1 is due in the first cycle after the edge that takes a request, T2 and T3 in the next two cycles, and T4 in the cycle after the first edge in T3 or TW that sees `bus_rdy` high. So `done` and the captured read data come 4 + N cycles after the accepting edge. The bench keeps a phase-by-phase expectation of every bus pin and handshake output. It changes inputs and compares all outputs at the falling edge, where each registered state has settled. It moves `bus_rdy` and `bus_ad_in` only at falling edges. This means each sampling edge in T3 or TW sees exactly the value planned for it. It also drives `bus_rdy` low in states that must ignore it.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  // Transfer phases of one bus cycle.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } tstate_e;

endpackage

// File: rtl/bus_seq_addr.sv
module bus_seq_addr #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              is_mem,
  output logic [ADDR_W-1:0] phys
);

  logic [ADDR_W-1:0] seg_base;
  logic [ADDR_W-1:0] off_ext;

  // Segment base: segment value moved up, low bits zero-filled.
  generate
    if (SEG_SHIFT > 0) begin : g_shift
      assign seg_base = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
    end else begin : g_flat
      assign seg_base = ADDR_W'(seg);
    end
  endgenerate

  assign off_ext = ADDR_W'(off);

  // Port space uses the offset as the port number; segment plays no part.
  always_comb begin
    if (is_mem) phys = seg_base + off_ext;
    else        phys = off_ext;
  end

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    rdy,
  output tstate_e state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_T1;
        ST_T1:   state <= ST_T2;
        ST_T2:   state <= ST_T3;
        ST_T3,
        ST_TW:   state <= rdy ? ST_T4 : ST_TW;
        ST_T4:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a low ready while waiting keeps the cycle stretched
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TW && !rdy) |=> (state == ST_TW));

  // R10: the T2 state always follows T1 with no extra cycle
  p_t1_to_t2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_T1) |=> (state == ST_T2));

endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic [ADDR_W-1:0] phys,
  input  logic              is_write,
  input  logic              is_mem,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              rdy,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              addr_stb,
  output logic              dir_tx,
  output logic              rd_n,
  output logic              wr_n,
  output logic              mem_sel,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic active;
  logic strobe_on;
  logic data_phase;
  logic ends_wait;

  assign active     = (state != ST_IDLE);
  assign strobe_on  = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign data_phase = strobe_on || (state == ST_T4);
  assign ends_wait  = ((state == ST_T3) || (state == ST_TW)) && rdy;

  always_comb begin
    addr_stb = (state == ST_T1);
    dir_tx   = active && is_write;
    mem_sel  = active && is_mem;
    a_hi     = active ? phys[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
    rd_n     = !(strobe_on && !is_write);
    wr_n     = !(strobe_on && is_write);
    done     = (state == ST_T4);
    ad_oe    = 1'b0;
    ad_out   = '0;
    if (state == ST_T1) begin
      ad_oe  = 1'b1;
      ad_out = phys[DATA_W-1:0];
    end else if (data_phase && is_write) begin
      ad_oe  = 1'b1;
      ad_out = wdata;
    end
  end

  // Read data is taken on the edge that closes the last T3/TW.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     rdata <= '0;
    else if (ends_wait && !is_write) rdata <= ad_in;
  end

  // R5: read and write strobes never active at once
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3: the address strobe lasts a single cycle
  p_addr_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: release of the read strobe coincides with completion
  p_read_release_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> done);

  // R6: shared lines are never driven while a read strobe is active
  p_read_lines_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SEG_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [DATA_W-1:0]        req_off,
  input  logic                     req_write,
  input  logic                     req_mem,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic                     bus_addr_stb,
  output logic                     bus_dir_tx,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic                     bus_mem_sel,
  input  logic                     bus_rdy
);

  tstate_e             state;
  logic                take;
  logic [ADDR_W-1:0]   phys_next;
  logic [ADDR_W-1:0]   phys_q;
  logic                write_q;
  logic                mem_q;
  logic [DATA_W-1:0]   wdata_q;

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign take      = req_valid && req_ready;

  bus_seq_addr #(
    .SEG_W(SEG_W), .OFF_W(DATA_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_addr (
    .seg(req_seg), .off(req_off), .is_mem(req_mem), .phys(phys_next)
  );

  // Request fields are held for the whole transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q  <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      wdata_q <= '0;
    end else if (take) begin
      phys_q  <= phys_next;
      write_q <= req_write;
      mem_q   <= req_mem;
      wdata_q <= req_wdata;
    end
  end

  bus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(take), .rdy(bus_rdy), .state(state)
  );

  bus_seq_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(state),
    .phys(phys_q), .is_write(write_q), .is_mem(mem_q), .wdata(wdata_q),
    .ad_in(bus_ad_in), .rdy(bus_rdy),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .a_hi(bus_a_hi),
    .addr_stb(bus_addr_stb), .dir_tx(bus_dir_tx),
    .rd_n(bus_rd_n), .wr_n(bus_wr_n), .mem_sel(bus_mem_sel),
    .done(done), .rdata(rsp_rdata)
  );

  // R9: a taken request opens T1 on the next cycle
  p_take_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> bus_addr_stb);

  // R2: port transfers keep the upper address lines at zero
  p_io_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_mem_sel) |-> (bus_a_hi == '0));

  // R9: a request offered while busy leaves the held fields untouched
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wdata_q));

endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/1ps
module bus_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_seg;
  logic [15:0] req_off;
  logic        req_write;
  logic        req_mem;
  logic [15:0] req_wdata;
  logic        busy;
  logic        done;
  logic [15:0] rsp_rdata;
  logic [15:0] bus_ad_out;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_in;
  logic [3:0]  bus_a_hi;
  logic        bus_addr_stb;
  logic        bus_dir_tx;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic        bus_mem_sel;
  logic        bus_rdy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_write(req_write),
    .req_mem(req_mem), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_a_hi(bus_a_hi), .bus_addr_stb(bus_addr_stb), .bus_dir_tx(bus_dir_tx),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_mem_sel(bus_mem_sel),
    .bus_rdy(bus_rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Phase codes used by the model: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4.
  task automatic expect_phase(input int ph, input logic wr, input logic mem,
                              input logic [19:0] pa, input logic [15:0] wd);
    logic act_ph;
    logic strobe;
    act_ph = (ph != 0);
    strobe = (ph >= 2 && ph <= 4);
    chk("R3 addr strobe", bus_addr_stb, ph == 1);
    chk("R4 direction", bus_dir_tx, act_ph && wr);
    chk("R2 mem select", bus_mem_sel, act_ph && mem);
    chk("R5 read strobe", bus_rd_n, !(strobe && !wr));
    chk("R5 write strobe", bus_wr_n, !(strobe && wr));
    chk("R1 upper address", bus_a_hi, act_ph ? pa[19:16] : 4'h0);
    chk("R9 busy", busy, act_ph);
    chk("R9 req_ready", req_ready, !act_ph);
    chk("R8 done", done, ph == 5);
    if (ph == 1) begin
      chk("R6 oe in T1", bus_ad_oe, 1'b1);
      chk("R1 low address", bus_ad_out, pa[15:0]);
    end else if (ph >= 2) begin
      chk("R6 oe data phase", bus_ad_oe, wr);
      if (wr) chk("R6 write data", bus_ad_out, wd);
    end else begin
      chk("R6 oe idle", bus_ad_oe, 1'b0);
    end
  endtask

  // One full transfer; starts one falling edge before the accepting edge.
  task automatic run_xfer(input logic [15:0] seg, input logic [15:0] off,
                          input logic wr, input logic mem, input logic [15:0] wd,
                          input int waits, input logic [15:0] rd_val);
    logic [19:0] pa;
    if (mem) pa = 20'(({4'h0, seg} << 4) + {4'h0, off});
    else     pa = {4'h0, off};
    @(negedge clk);
    expect_phase(0, 1'b0, 1'b0, 20'h0, 16'h0);
    req_valid = 1'b1; req_seg = seg; req_off = off;
    req_write = wr; req_mem = mem; req_wdata = wd;
    bus_rdy = 1'b0;                      // R7: ignored while idle
    @(negedge clk);                      // T1
    expect_phase(1, wr, mem, pa, wd);
    // R9: offer a different request while busy; it must not be taken
    req_seg = ~seg; req_off = ~off; req_write = ~wr; req_mem = ~mem; req_wdata = ~wd;
    @(negedge clk);                      // T2, ready low here has no effect (R7)
    expect_phase(2, wr, mem, pa, wd);
    @(negedge clk);                      // T3
    expect_phase(3, wr, mem, pa, wd);
    bus_ad_in = rd_val;
    bus_rdy = (waits == 0);
    for (int w = 1; w <= waits; w++) begin
      @(negedge clk);                    // TW
      expect_phase(4, wr, mem, pa, wd);
      bus_rdy = (w == waits);
      bus_ad_in = (w == waits) ? rd_val : ~rd_val;
    end
    @(negedge clk);                      // T4, R10 length 4+waits
    expect_phase(5, wr, mem, pa, wd);
    if (!wr) chk("R8 read data", rsp_rdata, rd_val);
    req_valid = 1'b0;
    bus_rdy = 1'b0;
  endtask

  initial begin
    int lim;
    lim = 20000;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > lim) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, lim);
        summary();
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0;
    req_write = 1'b0; req_mem = 1'b0; req_wdata = '0;
    bus_ad_in = '0; bus_rdy = 1'b1;
    repeat (3) @(negedge clk);
    expect_phase(0, 1'b0, 1'b0, 20'h0, 16'h0);   // R11 during reset
    chk("R11 strobe rd", bus_rd_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    expect_phase(0, 1'b0, 1'b0, 20'h0, 16'h0);   // R11 after reset

    // R1: memory read, no waits; 73A2:3216 -> 76C36
    run_xfer(16'h73A2, 16'h3216, 1'b0, 1'b1, 16'h0000, 0, 16'hBEEF);
    // R1 R6: memory write with two waits; 7370:561E -> 78D1E
    run_xfer(16'h7370, 16'h561E, 1'b1, 1'b1, 16'h5A5A, 2, 16'h0000);
    // R2: port read, segment ignored, one wait
    run_xfer(16'hFFFF, 16'hABCD, 1'b0, 1'b0, 16'h0000, 1, 16'h1234);
    // R2: port write, no waits
    run_xfer(16'h1234, 16'h00F0, 1'b1, 1'b0, 16'hC3C3, 0, 16'h0000);
    // R1: wrap past the top of memory, FFFF:0010 -> 00000
    run_xfer(16'hFFFF, 16'h0010, 1'b0, 1'b1, 16'h0000, 0, 16'h0F0F);
    // R7 R10: long stretch of five waits
    run_xfer(16'h0001, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 5, 16'h8001);
    // R8: previous read data held across a write
    run_xfer(16'h2000, 16'h0002, 1'b1, 1'b1, 16'hFFFF, 0, 16'h0000);
    chk("R8 rdata held", rsp_rdata, 16'h8001);

    @(negedge clk);
    expect_phase(0, 1'b0, 1'b0, 20'h0, 16'h0);   // R9 back to idle
    summary();
  end

endmodule